// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block watches inbound bus writes for a single programmable doorbell address. A device on the bus signals an interrupt by writing a vector number to that address. The block records each such message in a pending word, one bit per vector. It then folds all unmasked pending vectors into one level interrupt toward the CPU.

Software sets up and services the block through a 32-bit register port. It writes the doorbell address as two words. It writes an enable word that selects which vectors may be captured, and a mask word that keeps chosen pending vectors from raising the interrupt. The handler clears serviced vectors by writing ones to the pending word, which flips those bits.

The inbound side presents address, byte lanes, write data and a read/write flag in one cycle. The block answers with a combinational claim flag for writes it consumes. Reads are never claimed, so the surrounding fabric passes them upstream as ordinary reads.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: Register offsets (12-bit register address): 0x820 doorbell address bits 31:0, 0x824 doorbell address bits 63:32, 0x828 vector enable, 0x82C vector mask, 0x830 pending status. Each reads back what it holds. Any other offset reads zero and ignores writes.
- R2: A claimed doorbell write carrying vector N sets pending bit N only when enable bit N is 1. Other pending bits are unaffected.
- R3: After a claimed doorbell write, `irq` is 1 in the next cycle if any pending bit is set whose mask bit is 0. Otherwise `irq` keeps its previous level. Writing the mask alone never changes `irq`.
- R4: A register write to the status offset inverts every pending bit where the written data has a 1.
- R5: When a status write leaves the toggled pending word at zero, `irq` goes to 0 in the next cycle. A status write that leaves any bit set keeps `irq` unchanged.
- R6: `ib_claim` is 1 only while the enable word is nonzero and `ib_addr` equals the full 64-bit doorbell address.
- R7: Only writes with all four byte lanes active (`ib_be` = 4'hF) are claimed. Any access with `ib_write` = 0 is never claimed, even at the doorbell address.
- R8: The vector number is `ib_wdata[4:0]`, the least significant byte in little-endian lane order. Bits 31:5 are ignored.
- R9: After reset, all five registers read zero and `irq` is 0.
- R10: When a doorbell write and a status write occur in the same cycle, the toggle is applied first and the doorbell set second.
- R11: A register write to an address word or the enable word changes the doorbell decode from the next cycle on. Doorbell writes in the same cycle use the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ib_valid | input | 1 | Inbound access present |
| ib_write | input | 1 | Inbound access is a write (0 = read) |
| ib_addr | input | 64 | Inbound access address |
| ib_be | input | 4 | Inbound byte lanes, bit 0 = lowest byte |
| ib_wdata | input | 32 | Inbound write data, little-endian |
| ib_claim | output | 1 | Inbound write consumed as a doorbell |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
The bench builds the block with its defaults: a 64-bit address and all 32 vectors. Vector 31 is therefore capturable. The upper address word takes full part in the match, so a mismatch confined to bits 63:32 can be shown to block the claim. Random traffic keeps the doorbell address hit most of the time. It mixes in single-bit address misses, partial lanes, reads, and status and mask writes that often land in the same cycle as a doorbell. This drives the toggle-then-set ordering and the masked-pending cases.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;
    localparam int REG_AW = 12;
    localparam int REG_W  = 32;
    localparam int VEC_W  = 5;

    localparam logic [REG_AW-1:0] OFS_DB_LO  = 12'h820;
    localparam logic [REG_AW-1:0] OFS_DB_HI  = 12'h824;
    localparam logic [REG_AW-1:0] OFS_ENABLE = 12'h828;
    localparam logic [REG_AW-1:0] OFS_MASK   = 12'h82C;
    localparam logic [REG_AW-1:0] OFS_STATUS = 12'h830;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DB_LO,
        SEL_DB_HI,
        SEL_ENABLE,
        SEL_MASK,
        SEL_STATUS
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_DB_LO:  sel = SEL_DB_LO;
            OFS_DB_HI:  sel = SEL_DB_HI;
            OFS_ENABLE: sel = SEL_ENABLE;
            OFS_MASK:   sel = SEL_MASK;
            OFS_STATUS: sel = SEL_STATUS;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction
endpackage

// File: rtl/msi_db_cfg.sv
module msi_db_cfg
    import msi_db_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int NVEC   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  status_i,
    output logic [ADDR_W-1:0] db_addr_o,
    output logic [REG_W-1:0]  enable_o,
    output logic [REG_W-1:0]  mask_o,
    output logic              stat_wr_o,
    output logic [REG_W-1:0]  stat_wdata_o,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int HI_W = ADDR_W - REG_W;
    localparam logic [REG_W-1:0] VMASK = (NVEC >= REG_W) ? '1 : ((REG_W'(1) << NVEC) - 1'b1);

    typedef struct packed {
        logic [REG_W-1:0] lo;
        logic [HI_W-1:0]  hi;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] msk;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    reg_sel_e sel_wr, sel_rd;

    always_comb begin
        cfg_d  = cfg_q;
        sel_wr = reg_wr ? decode_offset(reg_addr) : SEL_NONE;
        case (sel_wr)
            SEL_DB_LO:  cfg_d.lo  = reg_wdata;
            SEL_DB_HI:  cfg_d.hi  = reg_wdata[HI_W-1:0];
            SEL_ENABLE: cfg_d.en  = reg_wdata & VMASK;
            SEL_MASK:   cfg_d.msk = reg_wdata & VMASK;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        sel_rd    = decode_offset(reg_addr);
        reg_rdata = '0;
        case (sel_rd)
            SEL_DB_LO:  reg_rdata = cfg_q.lo;
            SEL_DB_HI:  reg_rdata = REG_W'(cfg_q.hi);
            SEL_ENABLE: reg_rdata = cfg_q.en;
            SEL_MASK:   reg_rdata = cfg_q.msk;
            SEL_STATUS: reg_rdata = status_i;
            default:    reg_rdata = '0;
        endcase
    end

    assign db_addr_o    = {cfg_q.hi, cfg_q.lo};
    assign enable_o     = cfg_q.en;
    assign mask_o       = cfg_q.msk;
    assign stat_wr_o    = (sel_wr == SEL_STATUS);
    assign stat_wdata_o = reg_wdata & VMASK;

    // R11
    en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ENABLE) |=> (enable_o == ($past(reg_wdata) & VMASK)));

    // R1
    lo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DB_LO) |=> (db_addr_o[REG_W-1:0] == $past(reg_wdata)));
endmodule

// File: rtl/msi_db_match.sv
module msi_db_match
    import msi_db_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ib_valid,
    input  logic              ib_write,
    input  logic [ADDR_W-1:0] ib_addr,
    input  logic [3:0]        ib_be,
    input  logic [REG_W-1:0]  ib_wdata,
    input  logic [ADDR_W-1:0] db_addr_i,
    input  logic [REG_W-1:0]  enable_i,
    output logic              claim_o,
    output logic [VEC_W-1:0]  vec_o
);
    logic decode_on, addr_hit, full_word;

    always_comb begin
        decode_on = |enable_i;
        addr_hit  = (ib_addr == db_addr_i);
        full_word = (ib_be == 4'hF);
        claim_o   = ib_valid && ib_write && full_word && addr_hit && decode_on;
        vec_o     = ib_wdata[VEC_W-1:0];
    end

    // R7
    read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_valid && !ib_write) |-> !claim_o);

    // R6
    decode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (enable_i != '0 && ib_addr == db_addr_i));
endmodule

// File: rtl/msi_db_pend.sv
module msi_db_pend
    import msi_db_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_fire,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [REG_W-1:0] enable_i,
    input  logic [REG_W-1:0] mask_i,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] stat_wdata,
    output logic [REG_W-1:0] status_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [REG_W-1:0] status;
        logic             irq;
    } pend_t;

    pend_t            st_d, st_q;
    logic [REG_W-1:0] toggled, set_bits;

    always_comb begin
        st_d     = st_q;
        toggled  = st_q.status ^ (stat_wr ? stat_wdata : '0);
        set_bits = db_fire ? ((REG_W'(1) << vec_i) & enable_i) : '0;
        st_d.status = toggled | set_bits;
        if (stat_wr && toggled == '0)
            st_d.irq = 1'b0;
        if (db_fire && (st_d.status & ~mask_i) != '0)
            st_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;

    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(db_fire));

    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(stat_wr));

    // R2
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~$past(status_o) & ~($past(stat_wr) ? $past(stat_wdata) : '0)
          & ~$past(enable_i)) == '0));

    // R10
    stat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_fire && stat_wr && enable_i[vec_i]) |=> status_o[$past(vec_i)]);
endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
    import msi_db_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int NVEC   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ib_valid,
    input  logic              ib_write,
    input  logic [ADDR_W-1:0] ib_addr,
    input  logic [3:0]        ib_be,
    input  logic [REG_W-1:0]  ib_wdata,
    output logic              ib_claim,
    output logic              irq
);
    logic [ADDR_W-1:0] db_addr;
    logic [REG_W-1:0]  enable, mask, status, stat_wdata;
    logic              stat_wr;
    logic [VEC_W-1:0]  vec;

    msi_db_cfg #(.ADDR_W(ADDR_W), .NVEC(NVEC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status_i(status), .db_addr_o(db_addr),
        .enable_o(enable), .mask_o(mask), .stat_wr_o(stat_wr),
        .stat_wdata_o(stat_wdata), .reg_rdata(reg_rdata)
    );

    msi_db_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .ib_valid(ib_valid), .ib_write(ib_write),
        .ib_addr(ib_addr), .ib_be(ib_be), .ib_wdata(ib_wdata),
        .db_addr_i(db_addr), .enable_i(enable), .claim_o(ib_claim), .vec_o(vec)
    );

    msi_db_pend #(.NVEC(NVEC)) u_pend (
        .clk(clk), .rst_n(rst_n), .db_fire(ib_claim), .vec_i(vec),
        .enable_i(enable), .mask_i(mask), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .status_o(status), .irq_o(irq)
    );

    // R7
    claim_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_claim |-> (ib_be == 4'hF && ib_write));
endmodule

// File: tb/msi_doorbell_ctrl_test.sv
module msi_doorbell_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ib_valid = 1'b0, ib_write = 1'b0;
    logic [63:0] ib_addr = '0;
    logic [3:0]  ib_be = '0;
    logic [31:0] ib_wdata = '0;
    logic        ib_claim, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m_lo, m_hi, m_en, m_msk, m_st;
    logic        m_irq;

    msi_doorbell_ctrl uut (.*);

    always #2 clk = ~clk;

    function automatic logic exp_claim();
        return ib_valid && ib_write && ib_be == 4'hF &&
               ib_addr == {m_hi, m_lo} && m_en != 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic model_update(input logic claim);
        logic [31:0] tog, setb;
        logic        sw;
        sw   = reg_wr && reg_addr == 12'h830;
        tog  = m_st ^ (sw ? reg_wdata : 32'h0);
        setb = claim ? ((32'h1 << ib_wdata[4:0]) & m_en) : 32'h0;
        if (sw && tog == 0) m_irq = 1'b0;
        m_st = tog | setb;
        if (claim && (m_st & ~m_msk) != 0) m_irq = 1'b1;
        if (reg_wr) case (reg_addr)
            12'h820: m_lo  = reg_wdata;
            12'h824: m_hi  = reg_wdata;
            12'h828: m_en  = reg_wdata;
            12'h82C: m_msk = reg_wdata;
            default: ;
        endcase
    endtask

    task automatic step(input logic rw, input logic [11:0] ra, input logic [31:0] rd,
                        input logic v, input logic w, input logic [63:0] a,
                        input logic [3:0] be, input logic [31:0] d, input string tag);
        logic ec;
        @(negedge clk);
        reg_wr = rw; reg_addr = ra; reg_wdata = rd;
        ib_valid = v; ib_write = w; ib_addr = a; ib_be = be; ib_wdata = d;
        #1;
        ec = exp_claim();
        chk({tag, " claim"}, 32'(ib_claim), 32'(ec));
        model_update(ec);
        @(posedge clk);
        #1;
        chk({tag, " irq"}, 32'(irq), 32'(m_irq));
        reg_wr = 1'b0; ib_valid = 1'b0;
    endtask

    task automatic regw(input logic [11:0] ra, input logic [31:0] d, input string tag);
        step(1'b1, ra, d, 1'b0, 1'b0, 64'h0, 4'h0, 32'h0, tag);
    endtask

    task automatic dbw(input logic [63:0] a, input logic [31:0] d, input string tag);
        step(1'b0, 12'h0, 32'h0, 1'b1, 1'b1, a, 4'hF, d, tag);
    endtask

    task automatic rd(input logic [11:0] ra, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_wr = 1'b0; ib_valid = 1'b0; reg_addr = ra;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic rd_all(input string tag);
        rd(12'h820, m_lo, tag);
        rd(12'h824, m_hi, tag);
        rd(12'h828, m_en, tag);
        rd(12'h82C, m_msk, tag);
        rd(12'h830, m_st, tag);
    endtask

    localparam logic [63:0] DB = 64'h0000_0001_FEE0_0040;

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_lo = 0; m_hi = 0; m_en = 0; m_msk = 0; m_st = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset state
        rd_all("R9 reset");
        chk("R9 irq", 32'(irq), 32'h0);
        // R1: unmapped offset reads zero and ignores writes
        regw(12'h834, 32'hFFFF_FFFF, "R1 unmapped wr");
        rd(12'h834, 32'h0, "R1 unmapped rd");
        regw(12'h820, DB[31:0], "R1 lo");
        regw(12'h824, DB[63:32], "R1 hi");
        rd_all("R1 map");
        // R6: enable zero -> no decode
        dbw(DB, 32'h3, "R6 en zero");
        // R11: enable write, same-cycle doorbell uses old enable
        step(1'b1, 12'h828, 32'h8000_0008, 1'b1, 1'b1, DB, 4'hF, 32'h3, "R11 same cyc");
        rd(12'h830, 32'h0, "R11 status");
        // R2, R3: capture and raise
        dbw(DB, 32'h3, "R2 vec3");
        rd(12'h830, 32'h8, "R2 status");
        // R2: disabled vector ignored
        dbw(DB, 32'h5, "R2 disabled");
        rd(12'h830, 32'h8, "R2 status keep");
        // R8: upper data bits ignored (0xFF -> vector 31)
        dbw(DB, 32'hFFFF_FFFF, "R8 vec31");
        rd(12'h830, 32'h8000_0008, "R8 status");
        // R4, R5: partial toggle keeps irq, full clear drops it
        regw(12'h830, 32'h8000_0000, "R5 partial");
        rd(12'h830, 32'h8, "R4 toggle");
        regw(12'h830, 32'h8, "R5 clear");
        // R3: masked vector sets status but not irq
        regw(12'h82C, 32'h8, "R3 mask");
        dbw(DB, 32'h3, "R3 masked");
        rd(12'h830, 32'h8, "R3 status");
        regw(12'h82C, 32'h0, "R3 unmask no irq");
        // R10: toggle off and doorbell same cycle -> bit ends set
        step(1'b1, 12'h830, 32'h8, 1'b1, 1'b1, DB, 4'hF, 32'h3, "R10 order");
        rd(12'h830, 32'h8, "R10 status");
        // R7: partial lanes and reads not claimed
        step(1'b0, 12'h0, 32'h0, 1'b1, 1'b1, DB, 4'h7, 32'h1F, "R7 partial be");
        step(1'b0, 12'h0, 32'h0, 1'b1, 1'b0, DB, 4'hF, 32'h1F, "R7 read");
        // R6: high word mismatch
        dbw(DB ^ 64'h0000_0100_0000_0000, 32'h1F, "R6 hi miss");
        rd(12'h830, 32'h8, "R7 status");
        // R11: moved address takes effect next cycle
        regw(12'h820, 32'hFEE0_1000, "R11 move");
        dbw(DB, 32'h1F, "R11 old addr");
        dbw({DB[63:32], 32'hFEE0_1000}, 32'h1F, "R11 new addr");
        rd(12'h830, 32'h8000_0008, "R11 status");

        for (int i = 0; i < 4000; i++) begin
            int    op;
            logic  rw;
            logic [11:0] ra;
            logic [31:0] rdv;
            logic [63:0] a;
            logic [3:0]  be;
            logic        w;
            op  = $urandom_range(0, 99);
            rw  = 1'b0; ra = 12'h0; rdv = $urandom();
            case ($urandom_range(0, 9))
                0, 1: begin rw = 1'b1; ra = 12'h830; rdv = $urandom() & $urandom(); end
                2:    begin rw = 1'b1; ra = 12'h82C; end
                3:    begin rw = 1'b1; ra = 12'h828; rdv = ($urandom_range(0, 5) == 0) ? 32'h0 : $urandom(); end
                default: ;
            endcase
            a  = {m_hi, m_lo};
            if (op < 15) a[$urandom_range(0, 63)] ^= 1'b1;
            be = (op >= 15 && op < 22) ? 4'($urandom_range(0, 14)) : 4'hF;
            w  = !(op >= 22 && op < 28);
            step(rw, ra, rdv, op < 85, w, a, be, $urandom(), "R2 R3 R4 R5 R10 random");
            if (i % 100 == 99) rd_all("R1 random rb");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule